// File: doc/BRIEF.md
# Four-Function Integer ALU with Condition Flags

This block is a purely combinational arithmetic/logic unit for a word-wide datapath. It takes two operand words and a 2-bit function code. It returns the selected result: the sum, the difference, the bitwise AND or the bitwise XOR of the operands. It also returns three condition indications for that result: signed overflow, zero and carry/borrow. It has no clock and holds no state. A surrounding pipeline samples its outputs into whatever condition-code storage it keeps.

The add and subtract paths share one adder. Subtraction feeds the adder the inverted second operand and a carry-in of one. A parameter chooses the carry structure: a bit-serial ripple chain, or a carry-select arrangement of fixed-size blocks. For the carry-select variant, the word width must be a whole multiple of the block width.

Top module: `alu_cc`

## Requirements
- R1: With `op_i` = 0 the result equals `x_i + y_i` modulo 2^WIDTH.
- R2: With `op_i` = 1 the result equals `x_i - y_i` modulo 2^WIDTH.
- R3: With `op_i` = 2 the result is the bitwise AND of the operands.
- R4: With `op_i` = 3 the result is the bitwise XOR of the operands.
- R5: `zf_o` is 1 exactly when every bit of the result is 0, for all four codes.
- R6: For add, `cf_o` is the carry out of the most significant bit.
- R7: For subtract, `cf_o` is the borrow: 1 exactly when `y_i` is unsigned-greater than `x_i`.
- R8: For add, `of_o` is 1 exactly when both operands have equal sign bits and the result's sign bit differs from them.
- R9: For subtract, `of_o` is 1 exactly when the operand sign bits differ and the result's sign bit differs from that of `x_i`.
- R10: For AND and XOR (`op_i[1]` = 1), `of_o` and `cf_o` are both 0.
- R11: Outputs follow an input change with no clock edge in between; the block contains no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand (minuend for subtract) |
| y_i | input | WIDTH | Second operand (subtrahend for subtract) |
| op_i | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| res_o | output | WIDTH | Result of the selected function |
| of_o | output | 1 | Signed overflow of the selected function |
| zf_o | output | 1 | Result is all zeros |
| cf_o | output | 1 | Carry out for add, borrow for subtract |

## Verification
Two 4-bit instances, one per carry variant, are swept over every operand pair and code. This catches a carry chain or block-select mux that mishandles a single carry position, and a subtract path that leaves the borrow in carry polarity; such a design would invert `cf_o` on every subtraction. The 32-bit instance is driven with sign-boundary and all-ones operands. A design that derived overflow from the wrong operand's sign would flag 0x80000000 - 1 incorrectly, or miss 0x7FFFFFFF + 1. Equal operands under subtract and XOR check that zero detection sees the selected result and not the adder sum. Logic codes with operands that would carry check that the flags are forced quiet.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  localparam int ADDER_RIPPLE = 0;
  localparam int ADDER_CSEL   = 1;

endpackage

// File: rtl/alu_cc_adder.sv
module alu_cc_adder #(
  parameter int WIDTH   = 32,
  parameter int KIND    = 1,
  parameter int BLOCK_W = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int NBLK = WIDTH / BLOCK_W;

  if (KIND == 0) begin : g_ripple
    logic [WIDTH:0] c;
    assign c[0] = cin_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
      assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    end
    assign cout_o = c[WIDTH];
  end else begin : g_csel
    logic [NBLK:0] bc;
    assign bc[0] = cin_i;
    for (genvar k = 0; k < NBLK; k++) begin : g_blk
      logic [BLOCK_W:0] s0, s1;
      // both carry-in cases precomputed, block carry picks one
      assign s0 = {1'b0, a_i[k*BLOCK_W +: BLOCK_W]} + {1'b0, b_i[k*BLOCK_W +: BLOCK_W]};
      assign s1 = {1'b0, a_i[k*BLOCK_W +: BLOCK_W]} + {1'b0, b_i[k*BLOCK_W +: BLOCK_W]}
                  + (BLOCK_W+1)'(1);
      assign sum_o[k*BLOCK_W +: BLOCK_W] = bc[k] ? s1[BLOCK_W-1:0] : s0[BLOCK_W-1:0];
      assign bc[k+1] = bc[k] ? s1[BLOCK_W] : s0[BLOCK_W];
    end
    assign cout_o = bc[NBLK];
  end

  logic [WIDTH:0] sum_ref;
  assign sum_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    p_adder_sum_r1: assert ({cout_o, sum_o} == sum_ref)
      else $error("adder sum/carry mismatch");
  end

endmodule

// File: rtl/alu_cc_logic.sv
module alu_cc_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             xor_sel_i,
  output logic [WIDTH-1:0] res_o
);

  assign res_o = xor_sel_i ? (a_i ^ b_i) : (a_i & b_i);

  always_comb begin
    if (xor_sel_i) begin
      p_xor_self_r4: assert ((a_i == b_i) == (res_o == '0))
        else $error("xor zero mismatch");
    end else begin
      p_and_sub_r3: assert ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0)
        else $error("and sets bit absent from operand");
    end
  end

endmodule

// File: rtl/alu_cc_flags.sv
module alu_cc_flags #(
  parameter int WIDTH = 32
) (
  input  logic             is_arith_i,
  input  logic             is_sub_i,
  input  logic             a_msb_i,
  input  logic             b_msb_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             cout_i,
  output logic             of_o,
  output logic             zf_o,
  output logic             cf_o
);

  logic r_msb;
  assign r_msb = res_i[WIDTH-1];

  // b_msb_i is the adder's operand sign (already inverted for subtract)
  assign of_o = is_arith_i & (a_msb_i == b_msb_i) & (r_msb != a_msb_i);
  assign cf_o = is_arith_i & (cout_i ^ is_sub_i);
  assign zf_o = ~|res_i;

endmodule

// File: rtl/alu_cc.sv
module alu_cc
  import alu_cc_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int ADDER_KIND = ADDER_CSEL,
  parameter int BLOCK_W    = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             of_o,
  output logic             zf_o,
  output logic             cf_o
);

  alu_op_e        op;
  logic           is_sub, is_arith;
  logic [WIDTH-1:0] y_eff, sum, lres;
  logic           cout;

  assign op       = alu_op_e'(op_i);
  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign y_eff    = is_sub ? ~y_i : y_i;

  alu_cc_adder #(.WIDTH(WIDTH), .KIND(ADDER_KIND), .BLOCK_W(BLOCK_W)) u_add (
    .a_i   (x_i),
    .b_i   (y_eff),
    .cin_i (is_sub),
    .sum_o (sum),
    .cout_o(cout)
  );

  alu_cc_logic #(.WIDTH(WIDTH)) u_log (
    .a_i      (x_i),
    .b_i      (y_i),
    .xor_sel_i(op == OP_XOR),
    .res_o    (lres)
  );

  assign res_o = is_arith ? sum : lres;

  alu_cc_flags #(.WIDTH(WIDTH)) u_flg (
    .is_arith_i(is_arith),
    .is_sub_i  (is_sub),
    .a_msb_i   (x_i[WIDTH-1]),
    .b_msb_i   (y_eff[WIDTH-1]),
    .res_i     (res_o),
    .cout_i    (cout),
    .of_o      (of_o),
    .zf_o      (zf_o),
    .cf_o      (cf_o)
  );

  // reference arithmetic used only by the checks below
  logic [WIDTH:0] add_u, sub_u, add_s, sub_s;
  assign add_u = {1'b0, x_i} + {1'b0, y_i};
  assign sub_u = {1'b0, x_i} - {1'b0, y_i};
  assign add_s = {x_i[WIDTH-1], x_i} + {y_i[WIDTH-1], y_i};
  assign sub_s = {x_i[WIDTH-1], x_i} - {y_i[WIDTH-1], y_i};

  always_comb begin
    unique case (op)
      OP_ADD: begin
        p_add_res_r1: assert (res_o == add_u[WIDTH-1:0]) else $error("add result");
        p_add_carry_r6: assert (cf_o == add_u[WIDTH]) else $error("add carry");
        p_add_ovf_r8: assert (of_o == (add_s[WIDTH] ^ add_s[WIDTH-1])) else $error("add ovf");
      end
      OP_SUB: begin
        p_sub_res_r2: assert (res_o == sub_u[WIDTH-1:0]) else $error("sub result");
        p_sub_borrow_r7: assert (cf_o == (y_i > x_i)) else $error("sub borrow");
        p_sub_ovf_r9: assert (of_o == (sub_s[WIDTH] ^ sub_s[WIDTH-1])) else $error("sub ovf");
        p_sub_zero_r5: assert (zf_o == (x_i == y_i)) else $error("sub zero");
      end
      OP_AND: begin
        p_and_res_r3: assert (res_o == (x_i & y_i)) else $error("and result");
        p_and_quiet_r10: assert (!of_o && !cf_o) else $error("and flags");
      end
      OP_XOR: begin
        p_xor_res_r4: assert (res_o == (x_i ^ y_i)) else $error("xor result");
        p_xor_zero_r5: assert (zf_o == (x_i == y_i)) else $error("xor zero");
        p_xor_quiet_r10: assert (!of_o && !cf_o) else $error("xor flags");
      end
      default: ;
    endcase
  end

endmodule

// File: tb/alu_cc_test.sv
`timescale 1ns/1ps
module alu_cc_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] x_b, y_b, res_b;
  logic [1:0]  op_b;
  logic        of_b, zf_b, cf_b;

  logic [3:0]  xs, ys, res_r, res_c;
  logic [1:0]  ops;
  logic        of_r, zf_r, cf_r, of_c, zf_c, cf_c;

  alu_cc #(.WIDTH(32), .ADDER_KIND(1), .BLOCK_W(8)) uut (
    .x_i(x_b), .y_i(y_b), .op_i(op_b),
    .res_o(res_b), .of_o(of_b), .zf_o(zf_b), .cf_o(cf_b));

  alu_cc #(.WIDTH(4), .ADDER_KIND(0), .BLOCK_W(1)) uut_rip (
    .x_i(xs), .y_i(ys), .op_i(ops),
    .res_o(res_r), .of_o(of_r), .zf_o(zf_r), .cf_o(cf_r));

  alu_cc #(.WIDTH(4), .ADDER_KIND(1), .BLOCK_W(2)) uut_sel (
    .x_i(xs), .y_i(ys), .op_i(ops),
    .res_o(res_c), .of_o(of_c), .zf_o(zf_c), .cf_o(cf_c));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string res_tag(input int op);
    case (op)
      0: return "R1 add result";
      1: return "R2 sub result";
      2: return "R3 and result";
      default: return "R4 xor result";
    endcase
  endfunction

  function automatic string cf_tag(input int op);
    case (op)
      0: return "R6 add carry";
      1: return "R7 sub borrow";
      default: return "R10 logic carry";
    endcase
  endfunction

  function automatic string of_tag(input int op);
    case (op)
      0: return "R8 add overflow";
      1: return "R9 sub overflow";
      default: return "R10 logic overflow";
    endcase
  endfunction

  function automatic void ref_alu(input int w, input longint x, input longint y, input int op,
                                  output longint r, output bit of, output bit zf, output bit cf);
    longint m, half, sx, sy, s;
    m    = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    sx   = (x >= half) ? x - (half << 1) : x;
    sy   = (y >= half) ? y - (half << 1) : y;
    of = 0; cf = 0; s = 0;
    case (op)
      0: begin
        r  = (x + y) & m;
        cf = ((x + y) >> w) != 0;
        s  = sx + sy;
        of = (s >= half) || (s < -half);
      end
      1: begin
        r  = (x - y) & m;
        cf = y > x;
        s  = sx - sy;
        of = (s >= half) || (s < -half);
      end
      2: r = x & y;
      default: r = x ^ y;
    endcase
    zf = (r == 0);
  endfunction

  task automatic run_big(input logic [31:0] x, input logic [31:0] y, input logic [1:0] op);
    longint r; bit of, zf, cf;
    @(negedge clk);
    x_b = x; y_b = y; op_b = op;
    #1;
    ref_alu(32, longint'(x), longint'(y), int'(op), r, of, zf, cf);
    chk(res_tag(int'(op)), longint'(res_b), r);
    chk(cf_tag(int'(op)), longint'(cf_b), longint'(cf));
    chk(of_tag(int'(op)), longint'(of_b), longint'(of));
    chk("R5 zero flag", longint'(zf_b), longint'(zf));
  endtask

  initial begin
    logic [31:0] corner [12];
    corner = '{32'h0, 32'h1, 32'h2, 32'h7fffffff, 32'h80000000, 32'h80000001,
               32'hffffffff, 32'hfffffffe, 32'h55555555, 32'haaaaaaaa,
               32'h0000ffff, 32'hffff0000};
    x_b = '0; y_b = '0; op_b = 2'd0;
    xs = '0; ys = '0; ops = 2'd0;

    // idle state: zero operands, add
    @(negedge clk); #1;
    chk("R5 idle zero flag", longint'(zf_b), 1);
    chk("R6 idle carry", longint'(cf_b), 0);
    chk("R8 idle overflow", longint'(of_b), 0);

    // R11: two input changes inside one clock period, no edge between
    @(negedge clk);
    x_b = 32'd5; y_b = 32'd3; op_b = 2'd0;
    #1;   chk("R11 follow first change", longint'(res_b), 8);
    y_b = 32'd4;
    #0.5; chk("R11 follow second change", longint'(res_b), 9);
    op_b = 2'd1;
    #0.3; chk("R11 follow op change", longint'(res_b), 1);

    // named sign-boundary cases
    run_big(32'h7fffffff, 32'h1, 2'd0);          // R8 positive overflow
    run_big(32'h80000000, 32'h1, 2'd1);          // R9 negative overflow
    run_big(32'hffffffff, 32'h1, 2'd0);          // R6 carry, R5 zero
    run_big(32'h0, 32'h1, 2'd1);                 // R7 borrow
    run_big(32'hffffffff, 32'hffffffff, 2'd2);   // R10 quiet on AND
    run_big(32'h12345678, 32'h12345678, 2'd3);   // R5 zero on XOR

    // corner cross product on every code
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run_big(corner[i], corner[j], 2'(op));

    // random operands, some with equal operands
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rx, ry;
      rx = $urandom;
      ry = (i % 7 == 0) ? rx : $urandom;
      run_big(rx, ry, 2'(i % 4));
    end

    // exhaustive sweep of both 4-bit variants
    for (int op = 0; op < 4; op++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          longint r; bit of, zf, cf;
          @(negedge clk);
          xs = 4'(x); ys = 4'(y); ops = 2'(op);
          #1;
          ref_alu(4, longint'(x), longint'(y), op, r, of, zf, cf);
          chk(res_tag(op), longint'(res_r), r);
          chk(cf_tag(op), longint'(cf_r), longint'(cf));
          chk(of_tag(op), longint'(of_r), longint'(of));
          chk("R5 zero flag ripple", longint'(zf_r), longint'(zf));
          chk(res_tag(op), longint'(res_c), r);
          chk(cf_tag(op), longint'(cf_c), longint'(cf));
          chk(of_tag(op), longint'(of_c), longint'(of));
          chk("R5 zero flag csel", longint'(zf_c), longint'(zf));
        end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule